// File: doc/BRIEF.md
# Round-Robin Lane Distributor

This block takes a single serial stream of samples and deals it out across `LANES` parallel output lanes. Together the lanes carry one logical channel at `LANES` times the rate of any one lane. Sample k goes to lane k mod `LANES`. The input side and every lane use a valid/ready handshake. A sample moves only when the lane it is aimed at is ready, so no sample is lost or reordered when a lane stalls. Routing is combinational: a sample reaches its lane in the same cycle it is offered. The block holds no sample storage, only its routing state.

When `DUAL` is set, a second bank of `LANES` lanes (bank B) is present. Samples first fill the bank A lanes in round-robin order until each has taken 128 bits, which is 128/`SAMPLE_W` samples per lane. The same number of samples then goes round-robin to the bank B lanes. After that the block returns to bank A and the pattern repeats. Example: with 32-bit samples and three lanes, samples 0 to 11 go to bank A, samples 12 to 23 go to bank B, and sample 24 goes to bank A lane 0.

Top module: `lane_spreader`

## Requirements
- R1: Consecutive accepted samples target lanes 0, 1, …, LANES-1 in turn and then wrap to lane 0. In single-bank mode, sample k goes to lane k mod LANES.
- R2: At most one lane valid (across both banks) is high at any time. It is high only while `in_valid` is high, and it is the lane currently targeted.
- R3: `in_ready` equals the ready of the targeted lane. While the targeted lane is not ready, the routing state holds, so no sample is dropped or reordered.
- R4: The data of the targeted lane equals `in_data` in the same cycle. Bit field `[i*SAMPLE_W +: SAMPLE_W]` of a lane data bus belongs to lane i.
- R5: With `DUAL`=1, samples k with floor(k / (LANES*128/SAMPLE_W)) even go to bank A and the others go to bank B, always to lane k mod LANES. SAMPLE_W is 16, 32 or 64.
- R6: A synchronous reset, `rst` high at a rising edge, returns the targeting to bank A, lane 0, at the start of a burst. The next accepted sample counts as sample 0.
- R7: With LANES=1 and `DUAL`=0, the block is a pass-through: lane 0 valid equals `in_valid`, `in_ready` equals lane 0 ready, and the data is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Input sample accepted this cycle when high with in_valid |
| in_data | input | SAMPLE_W | Input sample |
| a_valid | output | LANES | Bank A lane valids, bit i is lane i |
| a_ready | input | LANES | Bank A lane readies |
| a_data | output | LANES*SAMPLE_W | Bank A lane data, lane i at [i*SAMPLE_W +: SAMPLE_W] |
| b_valid | output | LANES | Bank B lane valids (always 0 when DUAL=0) |
| b_ready | input | LANES | Bank B lane readies |
| b_data | output | LANES*SAMPLE_W | Bank B lane data, same layout as a_data |

## Verification
Every result is due in the same cycle as the stimulus: lane valid, lane data and `in_ready` follow the inputs combinationally. The routing state moves only at the rising edge that completes a handshake. The bench drives inputs at the falling edge and samples one time unit later, well before the next rising edge. Each sample therefore shows the state left by the previous edge plus the newly driven inputs. The bench keeps its own count of accepted samples and derives the expected bank and lane from that count arithmetically. A handshake counts only when the bench's own expected ready is high. Readies stall at random, and a reset in mid-stream restarts the count at zero.

// File: rtl/lane_spreader.sv
module lane_spreader #(
  parameter int SAMPLE_W = 32,
  parameter int LANES    = 3,
  parameter bit DUAL     = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [SAMPLE_W-1:0]         in_data,
  output logic [LANES-1:0]            a_valid,
  input  logic [LANES-1:0]            a_ready,
  output logic [LANES*SAMPLE_W-1:0]   a_data,
  output logic [LANES-1:0]            b_valid,
  input  logic [LANES-1:0]            b_ready,
  output logic [LANES*SAMPLE_W-1:0]   b_data
);

  localparam int PER = 128 / SAMPLE_W;
  localparam int PW  = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int RW  = (PER > 1) ? $clog2(PER) : 1;
  localparam logic [PW-1:0] LAST  = PW'(LANES - 1);
  localparam logic [RW-1:0] RLAST = RW'(PER - 1);

  logic [PW-1:0] ptr;
  logic [RW-1:0] rnd;
  logic          bank;
  logic          fire;

  assign in_ready = bank ? b_ready[ptr] : a_ready[ptr];
  assign fire     = in_valid && in_ready;
  assign a_data   = {LANES{in_data}};
  assign b_data   = {LANES{in_data}};

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign a_valid[i] = in_valid && !bank && (ptr == PW'(i));
    assign b_valid[i] = in_valid &&  bank && (ptr == PW'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr  <= '0;
      rnd  <= '0;
      bank <= 1'b0;
    end else if (fire) begin
      if (ptr == LAST) begin
        ptr <= '0;
        if (rnd == RLAST) begin
          rnd <= '0;
          if (DUAL) bank <= !bank;
        end else begin
          rnd <= rnd + 1'b1;
        end
      end else begin
        ptr <= ptr + 1'b1;
      end
    end
  end

  AST_ONE_LANE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({b_valid, a_valid}));  // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> ({b_valid, a_valid} == '0));  // R2
  AST_LANE_STEP: assert property (@(posedge clk) disable iff (rst)
    fire |=> (ptr == ((($past(ptr) == LAST)) ? '0 : $past(ptr) + 1'b1)));  // R1
  AST_NO_DROP: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_ready) |=> ($stable(ptr) && $stable(rnd) && $stable(bank)));  // R3
  AST_BANK_SWAP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(bank)) |-> ($past(fire) && $past(ptr) == LAST && $past(rnd) == RLAST));  // R5
  AST_RESET_HOME: assert property (@(posedge clk)
    rst |=> (ptr == '0 && rnd == '0 && !bank));  // R6

endmodule

// File: tb/test_lane_spreader.sv
module test_lane_spreader;
  localparam int CLK_P = 10;

  localparam int W1 = 32, N1 = 3;
  localparam int G1 = N1 * (128 / W1);
  localparam int W2 = 16, N2 = 4;
  localparam int W3 = 64;

  logic clk = 0, rst = 1;
  always #(CLK_P/2) clk = ~clk;

  int total = 0, bad = 0;
  int k1 = 0, k2 = 0;

  logic          v1, r1o; logic [W1-1:0] d1;
  logic [N1-1:0] av1, ar1, bv1, br1; logic [N1*W1-1:0] ad1, bd1;
  logic          v2, r2o; logic [W2-1:0] d2;
  logic [N2-1:0] av2, ar2, bv2, br2; logic [N2*W2-1:0] ad2, bd2;
  logic          v3, r3o; logic [W3-1:0] d3;
  logic [0:0]    av3, ar3, bv3, br3; logic [W3-1:0] ad3, bd3;

  lane_spreader #(.SAMPLE_W(W1), .LANES(N1), .DUAL(1'b1)) i_lane_spreader (
    .clk(clk), .rst(rst), .in_valid(v1), .in_ready(r1o), .in_data(d1),
    .a_valid(av1), .a_ready(ar1), .a_data(ad1),
    .b_valid(bv1), .b_ready(br1), .b_data(bd1));
  lane_spreader #(.SAMPLE_W(W2), .LANES(N2), .DUAL(1'b0)) i_lane_spreader_s (
    .clk(clk), .rst(rst), .in_valid(v2), .in_ready(r2o), .in_data(d2),
    .a_valid(av2), .a_ready(ar2), .a_data(ad2),
    .b_valid(bv2), .b_ready(br2), .b_data(bd2));
  lane_spreader #(.SAMPLE_W(W3), .LANES(1), .DUAL(1'b0)) i_lane_spreader_p (
    .clk(clk), .rst(rst), .in_valid(v3), .in_ready(r3o), .in_data(d3),
    .a_valid(av3), .a_ready(ar3), .a_data(ad3),
    .b_valid(bv3), .b_ready(br3), .b_data(bd3));

  task automatic chk(input string req, input logic [127:0] got, input logic [127:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  initial begin : watchdog
    #(CLK_P * 150000);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    int e1, e2;
    logic x1, x2;
    {v1, v2, v3} = '0; d1 = '0; d2 = '0; d3 = '0;
    ar1 = '0; br1 = '0; ar2 = '0; br2 = '0; ar3 = '0; br3 = '0;
    repeat (3) @(posedge clk);
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      rst = (c == 2000);
      v1 = ($urandom_range(0, 4) != 0); v2 = ($urandom_range(0, 4) != 0);
      v3 = ($urandom_range(0, 3) != 0);
      d1 = $urandom; d2 = W2'($urandom); d3 = {$urandom, $urandom};
      for (int i = 0; i < N1; i++) begin
        ar1[i] = ($urandom_range(0, 3) != 0); br1[i] = ($urandom_range(0, 3) != 0);
      end
      for (int i = 0; i < N2; i++) begin
        ar2[i] = ($urandom_range(0, 3) != 0); br2[i] = $urandom_range(0, 1);
      end
      ar3 = $urandom_range(0, 1); br3 = $urandom_range(0, 1);
      if (c == 0 || c == 2001) begin
        v1 = 1; v2 = 1; ar1 = '1; ar2 = '1;
      end
      #1;
      if (rst) begin
        k1 = 0; k2 = 0;
        continue;
      end
      e1 = ((k1 / G1) % 2) * N1 + (k1 % N1);
      e2 = k2 % N2;
      if (c == 0 || c == 2001) begin
        chk("R6 dual home", {bv1, av1}, 6'b000001);
        chk("R6 single home", av2, 4'b0001);
      end
      chk("R1/R5 dual lane valids", {bv1, av1}, v1 ? (6'b1 << e1) : 6'b0);
      x1 = (e1 >= N1) ? br1[e1 - N1] : ar1[e1];
      chk("R3 dual in_ready", r1o, x1);
      if (e1 >= N1) chk("R4 dual data", bd1[(e1-N1)*W1 +: W1], d1);
      else          chk("R4 dual data", ad1[e1*W1 +: W1], d1);
      chk("R1/R2 single lane valids", {bv2, av2}, v2 ? (8'b1 << e2) : 8'b0);
      x2 = ar2[e2];
      chk("R3 single in_ready", r2o, x2);
      chk("R4 single data", ad2[e2*W2 +: W2], d2);
      chk("R7 pass valid", {bv3, av3}, {1'b0, v3});
      chk("R7 pass ready", r3o, ar3);
      chk("R7 pass data", ad3, d3);
      if (v1 && x1) k1++;
      if (v2 && x2) k2++;
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule